// File: doc/BRIEF.md
# Guarded-Commit Predicate File

This block keeps a file of one-bit predicate registers and uses them to decide, per issued instruction, whether that instruction may change architectural state. A compare port takes a condition result produced elsewhere and, in one operation, writes that result to one named predicate and its inverse to a second named predicate. The compare carries its own qualifying predicate, so a compare whose qualifier is false leaves both destinations untouched.

Several instruction slots are presented each cycle, each with a valid bit and a predicate index. For each slot the block drives a commit-enable that is high only when the slot is valid and its predicate reads true. A slot with a false predicate still retires, but as a no-op. Predicate 0 always reads 1, so an instruction that names it always commits. A compare written in one cycle is visible to slots, to the compare qualifier and to the readback port in the very next cycle. A readback port exposes any predicate for inspection.

Top module: `pred_guard_file`

## Requirements
- R1: After reset, predicate 0 reads 1 and every other predicate reads 0 on the readback port.
- R2: A compare with `cmp_valid` high and a true qualifier writes `cmp_cond` to predicate `cmp_dst_t` and the inverse of `cmp_cond` to predicate `cmp_dst_f`; the new values appear on the readback port in the following cycle.
- R3: `slot_commit[k]` is 1 exactly when `slot_valid[k]` is 1 and the predicate selected by bits `6k+5:6k` of `slot_qual_idx` reads 1.
- R4: A slot with `slot_valid[k]` low drives `slot_commit[k]` low whatever its predicate reads.
- R5: A compare whose qualifying predicate (`cmp_qual_idx`) reads 0 writes neither destination; both keep their previous values.
- R6: Predicate 0 reads 1 at all times; a compare naming index 0 as a destination leaves it at 1 while still writing its other destination.
- R7: When `cmp_dst_t` equals `cmp_dst_f`, that predicate receives the inverse of `cmp_cond`.
- R8: A slot, or a compare qualifier, that reads a predicate in the cycle right after a compare wrote it sees the newly written value.
- R9: With `cmp_valid` low, no predicate changes.
- R10: Predicates not named as a destination of an effective compare keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | A compare is presented this cycle |
| cmp_qual_idx | input | 6 | Qualifying predicate of the compare |
| cmp_cond | input | 1 | Condition result to record |
| cmp_dst_t | input | 6 | Destination receiving the condition |
| cmp_dst_f | input | 6 | Destination receiving the inverse |
| slot_valid | input | 3 | Per-slot valid bits |
| slot_qual_idx | input | 18 | Per-slot predicate index, slot k in bits 6k+5:6k |
| slot_commit | output | 3 | Per-slot commit-enable |
| rd_idx | input | 6 | Readback index |
| rd_val | output | 1 | Value of the predicate at `rd_idx` |

## Verification
The main function is driven with directed compares that set a pair and are read back the next cycle, compares blocked by a false qualifier against compares enabled by a freshly written one, colliding destinations, destinations at index 0 and idle cycles with `cmp_valid` low. Back-to-back compares to the same predicate separate a design that forwards the newest value from one that shows a stale value for a cycle. A long random run with mixed valid bits and indices across the whole file, followed by full readback sweeps, separates correct pair writes from writes that spill onto neighbouring predicates or drop the qualifier.

// File: rtl/pgf_pkg.sv
`timescale 1ns/1ps
package pgf_pkg;
   typedef enum logic [0:0] {
      PGF_WR_DIRECT = 1'b0,
      PGF_WR_STAGED = 1'b1
   } pgf_wr_mode_e;

   typedef struct packed {
      logic en;
      logic val;
   } pgf_wr_ctl_t;
endpackage

// File: rtl/pgf_write_ctrl.sv
`timescale 1ns/1ps
module pgf_write_ctrl #(
   parameter int IDXW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmp_valid,
   input  logic            qual_ok,
   input  logic            cond,
   input  logic [IDXW-1:0] dst_t,
   input  logic [IDXW-1:0] dst_f,
   output pgf_pkg::pgf_wr_ctl_t wr_t,
   output pgf_pkg::pgf_wr_ctl_t wr_f
);
   logic fire;
   logic collide;

   assign fire    = cmp_valid & qual_ok;
   assign collide = (dst_t == dst_f);

   always_comb begin
      wr_t.en  = fire && !collide && (dst_t != '0);
      wr_t.val = cond;
      wr_f.en  = fire && (dst_f != '0);
      wr_f.val = ~cond;
   end

   // R6: index 0 is never handed to the storage as a write target
   assert_no_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_t.en || wr_f.en) |-> !((wr_t.en && dst_t == '0) || (wr_f.en && dst_f == '0)));

   // R5 / R9: no write without a valid, qualified compare
   assert_write_needs_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_valid || !qual_ok) |-> (!wr_t.en && !wr_f.en));
endmodule

// File: rtl/pgf_array.sv
`timescale 1ns/1ps
module pgf_array #(
   parameter int NPRED   = 64,
   parameter int NRD     = 4,
   parameter int WR_MODE = 0,
   localparam int IDXW   = $clog2(NPRED)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  pgf_pkg::pgf_wr_ctl_t wr_t,
   input  logic [IDXW-1:0]      wr_t_idx,
   input  pgf_pkg::pgf_wr_ctl_t wr_f,
   input  logic [IDXW-1:0]      wr_f_idx,
   input  logic [NRD*IDXW-1:0]  rd_idx,
   output logic [NRD-1:0]       rd_val
);
   logic [NPRED-1:1] state;
   logic [NPRED-1:0] eff;

   generate
      if (WR_MODE == int'(pgf_pkg::PGF_WR_DIRECT)) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               state <= '0;
            end else begin
               for (int i = 1; i < NPRED; i++) begin
                  if (wr_t.en && wr_t_idx == IDXW'(i)) state[i] <= wr_t.val;
                  if (wr_f.en && wr_f_idx == IDXW'(i)) state[i] <= wr_f.val;
               end
            end
         end
         assign eff = {state, 1'b1};
      end else begin : g_staged
         pgf_pkg::pgf_wr_ctl_t pend_t, pend_f;
         logic [IDXW-1:0]      pend_t_idx, pend_f_idx;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               state      <= '0;
               pend_t     <= '0;
               pend_f     <= '0;
               pend_t_idx <= '0;
               pend_f_idx <= '0;
            end else begin
               for (int i = 1; i < NPRED; i++) begin
                  if (pend_t.en && pend_t_idx == IDXW'(i)) state[i] <= pend_t.val;
                  if (pend_f.en && pend_f_idx == IDXW'(i)) state[i] <= pend_f.val;
               end
               pend_t     <= wr_t;
               pend_f     <= wr_f;
               pend_t_idx <= wr_t_idx;
               pend_f_idx <= wr_f_idx;
            end
         end

         always_comb begin
            eff = {state, 1'b1};
            if (pend_t.en) eff[pend_t_idx] = pend_t.val;
            if (pend_f.en) eff[pend_f_idx] = pend_f.val;
            eff[0] = 1'b1;
         end
      end
   endgenerate

   generate
      for (genvar r = 0; r < NRD; r++) begin : g_rd
         assign rd_val[r] = eff[rd_idx[r*IDXW +: IDXW]];
      end
   endgenerate

   // R6: predicate 0 reads as 1 through every read port
   generate
      for (genvar r = 0; r < NRD; r++) begin : g_rd_chk
         assert_zero_reads_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx[r*IDXW +: IDXW] == '0) |-> rd_val[r]);
      end
   endgenerate
endmodule

// File: rtl/pgf_slot_gate.sv
`timescale 1ns/1ps
module pgf_slot_gate (
   input  logic valid,
   input  logic pred,
   output logic commit
);
   assign commit = valid & pred;
endmodule

// File: rtl/pred_guard_file.sv
`timescale 1ns/1ps
module pred_guard_file #(
   parameter int NPRED   = 64,
   parameter int NSLOT   = 3,
   parameter int WR_MODE = 1,
   localparam int IDXW   = $clog2(NPRED),
   localparam int NRD    = NSLOT + 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmp_valid,
   input  logic [IDXW-1:0]       cmp_qual_idx,
   input  logic                  cmp_cond,
   input  logic [IDXW-1:0]       cmp_dst_t,
   input  logic [IDXW-1:0]       cmp_dst_f,
   input  logic [NSLOT-1:0]      slot_valid,
   input  logic [NSLOT*IDXW-1:0] slot_qual_idx,
   output logic [NSLOT-1:0]      slot_commit,
   input  logic [IDXW-1:0]       rd_idx,
   output logic                  rd_val
);
   generate
      if (NPRED < 2 || (NPRED & (NPRED - 1)) != 0) begin : g_bad_npred
         $error("pred_guard_file: NPRED must be a power of two of at least 2");
      end
      if (NSLOT < 1) begin : g_bad_nslot
         $error("pred_guard_file: NSLOT must be at least 1");
      end
      if (WR_MODE != 0 && WR_MODE != 1) begin : g_bad_mode
         $error("pred_guard_file: WR_MODE must be 0 or 1");
      end
   endgenerate

   localparam int RP_QUAL = NSLOT;
   localparam int RP_RD   = NSLOT + 1;
   localparam int RP_OLD  = NSLOT + 2;

   logic [NRD*IDXW-1:0]  rp_idx;
   logic [NRD-1:0]       rp_val;
   pgf_pkg::pgf_wr_ctl_t wr_t, wr_f;
   logic                 qual_ok;
   logic                 old_t_val;

   assign rp_idx  = {cmp_dst_t, rd_idx, cmp_qual_idx, slot_qual_idx};
   assign qual_ok   = rp_val[RP_QUAL];
   assign rd_val    = rp_val[RP_RD];
   assign old_t_val = rp_val[RP_OLD];

   pgf_write_ctrl #(.IDXW(IDXW)) u_wctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_valid (cmp_valid),
      .qual_ok   (qual_ok),
      .cond      (cmp_cond),
      .dst_t     (cmp_dst_t),
      .dst_f     (cmp_dst_f),
      .wr_t      (wr_t),
      .wr_f      (wr_f)
   );

   pgf_array #(.NPRED(NPRED), .NRD(NRD), .WR_MODE(WR_MODE)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_t     (wr_t),
      .wr_t_idx (cmp_dst_t),
      .wr_f     (wr_f),
      .wr_f_idx (cmp_dst_f),
      .rd_idx   (rp_idx),
      .rd_val   (rp_val)
   );

   generate
      for (genvar k = 0; k < NSLOT; k++) begin : g_slot
         pgf_slot_gate u_gate (
            .valid  (slot_valid[k]),
            .pred   (rp_val[k]),
            .commit (slot_commit[k])
         );
         // R4: an invalid slot never commits
         assert_idle_slot_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_valid[k] |-> !slot_commit[k]);
      end
   endgenerate

   // R2: the true destination shows the condition one cycle later
   assert_true_dst_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && qual_ok && cmp_dst_t != '0 && cmp_dst_t != cmp_dst_f)
      |=> (rd_idx != $past(cmp_dst_t) || rd_val == $past(cmp_cond)));

   // R2: the false destination shows the inverse one cycle later
   assert_false_dst_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && qual_ok && cmp_dst_f != '0)
      |=> (rd_idx != $past(cmp_dst_f) || rd_val == !$past(cmp_cond)));

   // R5: a blocked compare leaves its true destination as it was
   assert_blocked_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !qual_ok)
      |=> (rd_idx != $past(cmp_dst_t) || rd_val == $past(old_t_val)));

   // R7: colliding destinations take the inverse
   assert_collide_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && qual_ok && cmp_dst_t == cmp_dst_f && cmp_dst_t != '0)
      |=> (rd_idx != $past(cmp_dst_t) || rd_val == !$past(cmp_cond)));
endmodule

// File: tb/pred_guard_file_tb.sv
`timescale 1ns/1ps
module pred_guard_file_tb;
   typedef struct {
      logic [2:0] commit;
      logic       rdv;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid = 1'b0;
   logic [5:0]  cmp_qual_idx = '0;
   logic        cmp_cond = 1'b0;
   logic [5:0]  cmp_dst_t = '0;
   logic [5:0]  cmp_dst_f = '0;
   logic [2:0]  slot_valid = '0;
   logic [17:0] slot_qual_idx = '0;
   logic [2:0]  slot_commit;
   logic [5:0]  rd_idx = '0;
   logic        rd_val;

   int   n_checks = 0;
   int   n_fail   = 0;
   logic [63:0] model;
   exp_t q[$];
   bit   finished = 0;

   always #2.5 clk = ~clk;

   pred_guard_file u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_qual_idx(cmp_qual_idx),
      .cmp_cond(cmp_cond), .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
      .slot_valid(slot_valid), .slot_qual_idx(slot_qual_idx), .slot_commit(slot_commit),
      .rd_idx(rd_idx), .rd_val(rd_val)
   );

   task automatic do_cycle(input logic cv, input logic [5:0] cq, input logic cc,
                           input logic [5:0] dt, input logic [5:0] df,
                           input logic [2:0] sv, input logic [5:0] s0,
                           input logic [5:0] s1, input logic [5:0] s2,
                           input logic [5:0] ri, input string tag);
      exp_t e;
      @(negedge clk);
      cmp_valid = cv; cmp_qual_idx = cq; cmp_cond = cc;
      cmp_dst_t = dt; cmp_dst_f = df;
      slot_valid = sv; slot_qual_idx = {s2, s1, s0}; rd_idx = ri;
      e.commit = {sv[2] & model[s2], sv[1] & model[s1], sv[0] & model[s0]};
      e.rdv = model[ri];
      e.tag = tag;
      q.push_back(e);
      if (cv && model[cq]) begin
         if (dt != 0 && dt != df) model[dt] = cc;
         if (df != 0) model[df] = !cc;
      end
   endtask

   task automatic idle_read(input logic [5:0] ri, input string tag);
      do_cycle(1'b0, 6'd0, 1'b0, 6'd0, 6'd0, 3'b000, 6'd0, 6'd0, 6'd0, ri, tag);
   endtask

   task automatic sweep(input string tag);
      for (int i = 0; i < 64; i++) idle_read(6'(i), tag);
   endtask

   // monitor: pops expected items and compares
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (slot_commit !== e.commit || rd_val !== e.rdv) begin
               n_fail++;
               $display("FAIL %s: commit=%b rd_val=%b expected commit=%b rd_val=%b (rd_idx=%0d)",
                        e.tag, slot_commit, rd_val, e.commit, e.rdv, rd_idx);
            end
         end
      end
   end

   initial begin
      #500000;
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      model = 64'h1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values across the file; R4: invalid slots
      sweep("R1");
      do_cycle(0, 0, 0, 0, 0, 3'b000, 6'd0, 6'd0, 6'd0, 6'd0, "R4");
      // R2: set pair 5/6 with unconditional compare
      do_cycle(1, 6'd0, 1, 6'd5, 6'd6, 3'b000, 0, 0, 0, 6'd0, "R2");
      // R8 / R3: slots read the pair the cycle after
      do_cycle(0, 0, 0, 0, 0, 3'b111, 6'd5, 6'd6, 6'd0, 6'd5, "R8");
      do_cycle(0, 0, 0, 0, 0, 3'b010, 6'd5, 6'd0, 6'd6, 6'd6, "R3");
      do_cycle(0, 0, 0, 0, 0, 3'b101, 6'd6, 6'd5, 6'd5, 6'd6, "R4");
      // R5: compare qualified by false predicate 6
      do_cycle(1, 6'd6, 1, 6'd7, 6'd8, 3'b000, 0, 0, 0, 6'd0, "R5");
      do_cycle(0, 0, 0, 0, 0, 3'b011, 6'd7, 6'd8, 6'd0, 6'd7, "R5");
      idle_read(6'd8, "R5");
      // R2: qualified by true predicate 5, cond 0
      do_cycle(1, 6'd5, 0, 6'd7, 6'd8, 3'b000, 0, 0, 0, 6'd0, "R2");
      do_cycle(0, 0, 0, 0, 0, 3'b011, 6'd7, 6'd8, 6'd0, 6'd8, "R2");
      // R7: colliding destinations
      do_cycle(1, 6'd0, 1, 6'd9, 6'd9, 3'b000, 0, 0, 0, 6'd0, "R7");
      idle_read(6'd9, "R7");
      do_cycle(1, 6'd0, 0, 6'd9, 6'd9, 3'b000, 0, 0, 0, 6'd0, "R7");
      do_cycle(0, 0, 0, 0, 0, 3'b001, 6'd9, 0, 0, 6'd9, "R7");
      // R6: writes naming index 0
      do_cycle(1, 6'd0, 1, 6'd0, 6'd10, 3'b000, 0, 0, 0, 6'd0, "R6");
      do_cycle(0, 0, 0, 0, 0, 3'b111, 6'd0, 6'd10, 6'd0, 6'd0, "R6");
      do_cycle(1, 6'd0, 1, 6'd11, 6'd0, 3'b000, 0, 0, 0, 6'd0, "R6");
      do_cycle(0, 0, 0, 0, 0, 3'b001, 6'd0, 6'd11, 6'd0, 6'd11, "R6");
      idle_read(6'd0, "R6");
      // R9: compare not valid
      do_cycle(0, 6'd0, 1, 6'd12, 6'd13, 3'b000, 0, 0, 0, 6'd0, "R9");
      do_cycle(0, 0, 0, 0, 0, 3'b001, 6'd12, 0, 0, 6'd13, "R9");
      // R8: back-to-back compares; second qualified by the first's result
      do_cycle(1, 6'd0, 1, 6'd14, 6'd15, 3'b000, 0, 0, 0, 6'd0, "R8");
      do_cycle(1, 6'd14, 0, 6'd14, 6'd16, 3'b111, 6'd14, 6'd15, 6'd16, 6'd14, "R8");
      do_cycle(0, 0, 0, 0, 0, 3'b111, 6'd14, 6'd15, 6'd16, 6'd16, "R8");
      do_cycle(1, 6'd15, 1, 6'd14, 6'd16, 3'b000, 0, 0, 0, 6'd0, "R8");
      do_cycle(0, 0, 0, 0, 0, 3'b111, 6'd14, 6'd15, 6'd16, 6'd14, "R8");
      // R10: retention across the file
      sweep("R10");
      // random traffic
      for (int n = 0; n < 400; n++) begin
         do_cycle(1'($urandom), 6'($urandom), 1'($urandom), 6'($urandom), 6'($urandom),
                  3'($urandom), 6'($urandom), 6'($urandom), 6'($urandom), 6'($urandom), "R3");
      end
      sweep("R10");
      repeat (3) @(negedge clk);
      #2;
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule